// File: doc/BRIEF.md
# EDO DRAM Data-Pin Drive Control

This block is a clock-based model of the logic that decides whether the data pins of an extended-data-out DRAM are driven (Low-Z) or left floating (High-Z). It watches the four active-low control strobes: row strobe, column strobe, output enable and write enable. Every pulse and setup width is measured in whole clock cycles by saturating run counters. The block does not model the storage array, the address path or the analog turn-on and turn-off delays.

The drive state has memory. A read column strobe latches a data-valid flag. A short output-enable or write-enable pulse only interrupts the drive for a while. A pulse that is long enough sets a sticky lock-off flag. Once that flag is set, the pins stay floating until a new read column cycle starts, which is a column-strobe falling edge seen while write enable is high.

Every input is sampled on the rising clock edge. The outputs are combinational functions of the state held after that edge. An "edge" in the requirements below means a rising clock edge at which the named input level is sampled.

Top module: `edo_dq_ctrl`

## Requirements
- R1: At an edge where ras_n=0, we_n=1 and cas_n is 0 after having been 1 at the previous edge (a read column fall), data_valid becomes 1. If output enable has been sampled low for at least T_OES edges, with no lock and we_n=1, dq_drive becomes 1 after that same edge.
- R2: Take an access that is being driven and sample oe_n=1. dq_drive stays 1 through the first T_OD consecutive edges with oe_n high and is 0 from edge T_OD+1 of that run onward.
- R3: Take an unlocked access. After oe_n returns low, dq_drive is 0 until oe_n has been sampled low at T_OES consecutive edges, and it is 1 again after that edge. data_valid is unchanged throughout.
- R4: A run of T_OEP consecutive edges with oe_n=1 sets the lock. dq_drive then stays 0 after oe_n returns low, and data_valid stays 1.
- R5: The lock is cleared only by a read column fall as defined in R1, after which dq_drive follows R1.
- R6: A run of T_OEHC consecutive edges with both oe_n=1 and cas_n=1 sets the lock, even when that run is shorter than T_OEP.
- R7: After any edge at which we_n=0 is sampled, dq_drive is 0.
- R8: A we_n low run shorter than T_WPZ edges does not lock. dq_drive returns to 1 after the first edge that samples we_n high again.
- R9: A we_n low run of T_WPZ edges sets the lock. The pins then stay undriven after we_n returns high, until a read column fall.
- R10: A column fall sampled with we_n=0 (a write column cycle) clears data_valid, so dq_drive stays 0 after we_n returns high.
- R11: After an edge that samples ras_n=1 and cas_n=1, both dq_drive and data_valid are 0.
- R12: A column fall sampled while ras_n=1 does not set data_valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| dq_drive | output | 1 | 1 when the data pins are driven (Low-Z) |
| data_valid | output | 1 | 1 while read data is latched for the pins |

## Verification
The properties take the strobes as already synchronous to the clock and assume that reset is held long enough for the strobes to settle at their idle-high level. The output-disable property relies on its own count of consecutive high output-enable samples. The read-fall property assumes the column strobe was sampled high before the fall. The bench changes strobes only on the falling clock edge and holds every level for whole cycles. It keeps each access inside a row-strobe-low window that is entered from standby, so every column fall it makes is clean.

// File: rtl/edo_dq_pkg.sv
// Package for the data-pin drive control.
// Holds the flag bundle passed from access tracking to the drive gate,
// the default timing values in cycles, and a width helper.
package edo_dq_pkg;

    // Access state shared between the tracker and the drive gate.
    typedef struct packed {
        logic lock;   // sticky pins-off flag
        logic valid;  // read data latched
    } acc_flags_t;

    localparam int unsigned DEF_T_OD   = 2;
    localparam int unsigned DEF_T_OES  = 2;
    localparam int unsigned DEF_T_OEHC = 3;
    localparam int unsigned DEF_T_OEP  = 4;
    localparam int unsigned DEF_T_WPZ  = 3;

    // Width that can hold value+1 without wrapping into the compare range.
    function automatic int unsigned run_width(input int unsigned max_val);
        return $clog2(max_val + 2);
    endfunction

endpackage

// File: rtl/edo_run_counter.sv
// Saturating run-length counter.
// Counts consecutive clock edges at which 'active' is sampled high and
// drops to zero on the first edge at which it is low.
// Assumes CW is wide enough that the saturation value exceeds every limit
// compared against it.
module edo_run_counter #(
    parameter int unsigned CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    output logic [CW-1:0] run_q
);

    localparam logic [CW-1:0] RUN_MAX = '1;

    // Count up while active, saturate at all ones, clear when inactive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (!active) begin
            run_q <= '0;
        end else if (run_q != RUN_MAX) begin
            run_q <= run_q + 1'b1;
        end
    end

endmodule

// File: rtl/edo_access_track.sv
// Access tracker.
// Detects read and write column falls and the standby state, keeps the
// latched-data flag and the sticky lock-off flag.
// Assumes the run counters present the count from before the current edge,
// so reaching LIMIT at this edge means count == LIMIT-1 with the input active.
module edo_access_track
    import edo_dq_pkg::*;
#(
    parameter int unsigned CW     = 4,
    parameter int unsigned T_OEHC = DEF_T_OEHC,
    parameter int unsigned T_OEP  = DEF_T_OEP,
    parameter int unsigned T_WPZ  = DEF_T_WPZ
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ras_n,
    input  logic          cas_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic [CW-1:0] oe_hi_run,
    input  logic [CW-1:0] oe_hc_run,
    input  logic [CW-1:0] we_lo_run,
    output acc_flags_t    flags
);

    localparam logic [CW-1:0] OEP_PRE  = CW'(T_OEP - 1);
    localparam logic [CW-1:0] OEHC_PRE = CW'(T_OEHC - 1);
    localparam logic [CW-1:0] WPZ_PRE  = CW'(T_WPZ - 1);

    logic cas_q;
    logic cas_fall, read_fall, write_fall, standby;
    logic lock_set;

    // Remember the previous column-strobe level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) cas_q <= 1'b1;
        else        cas_q <= cas_n;
    end

    // Decode the column-cycle events and the qualifying pulse widths.
    always_comb begin
        cas_fall   = cas_q && !cas_n;
        read_fall  = cas_fall && !ras_n && we_n;
        write_fall = cas_fall && !we_n;
        standby    = ras_n && cas_n;
        lock_set   = (oe_n && (oe_hi_run == OEP_PRE))
                   || (oe_n && cas_n && (oe_hc_run == OEHC_PRE))
                   || (!we_n && (we_lo_run == WPZ_PRE));
    end

    // Sticky lock: a qualifying pulse sets it, a read column fall clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)         flags.lock <= 1'b0;
        else if (lock_set)  flags.lock <= 1'b1;
        else if (read_fall) flags.lock <= 1'b0;
    end

    // Latched data: set on a read fall, dropped on a write fall or in standby.
    always_ff @(posedge clk) begin
        if (!rst_n)          flags.valid <= 1'b0;
        else if (standby)    flags.valid <= 1'b0;
        else if (read_fall)  flags.valid <= 1'b1;
        else if (write_fall) flags.valid <= 1'b0;
    end

endmodule

// File: rtl/edo_drive_gate.sv
// Drive gate.
// Combines latched data, the lock and the output-enable and write-enable
// run lengths into the final pin-drive decision.
// Assumes a nonzero high run means output enable was last sampled high, and
// a nonzero write-low run means write enable was last sampled low.
module edo_drive_gate
    import edo_dq_pkg::*;
#(
    parameter int unsigned CW    = 4,
    parameter int unsigned T_OD  = DEF_T_OD,
    parameter int unsigned T_OES = DEF_T_OES
) (
    input  acc_flags_t    flags,
    input  logic [CW-1:0] oe_hi_run,
    input  logic [CW-1:0] oe_lo_run,
    input  logic [CW-1:0] we_lo_run,
    output logic          dq_drive
);

    localparam logic [CW-1:0] OD_LIM  = CW'(T_OD);
    localparam logic [CW-1:0] OES_LIM = CW'(T_OES);

    logic oe_ok;

    // Output enable allows driving within the disable delay or after setup.
    always_comb begin
        if (oe_hi_run != '0) oe_ok = (oe_hi_run <= OD_LIM);
        else                 oe_ok = (oe_lo_run >= OES_LIM);
        dq_drive = flags.valid && !flags.lock && (we_lo_run == '0) && oe_ok;
    end

endmodule

// File: rtl/edo_dq_ctrl.sv
// Top: data-pin drive control for an extended-data-out DRAM model.
// Four run counters measure the strobe pulses. The tracker keeps the
// access flags and the gate forms the drive output.
// Assumes all strobes are synchronous to clk and all T_* values are at least 1.
module edo_dq_ctrl
    import edo_dq_pkg::*;
#(
    parameter int unsigned T_OD   = DEF_T_OD,
    parameter int unsigned T_OES  = DEF_T_OES,
    parameter int unsigned T_OEHC = DEF_T_OEHC,
    parameter int unsigned T_OEP  = DEF_T_OEP,
    parameter int unsigned T_WPZ  = DEF_T_WPZ
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic oe_n,
    input  logic we_n,
    output logic dq_drive,
    output logic data_valid
);

    localparam int unsigned MAX_A = (T_OD > T_OES) ? T_OD : T_OES;
    localparam int unsigned MAX_B = (T_OEHC > T_OEP) ? T_OEHC : T_OEP;
    localparam int unsigned MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int unsigned MAX_T = (MAX_C > T_WPZ) ? MAX_C : T_WPZ;
    localparam int unsigned CW    = run_width(MAX_T);
    localparam int unsigned NRUN  = 4;
    localparam int unsigned IX_OE_HI = 0;
    localparam int unsigned IX_OE_LO = 1;
    localparam int unsigned IX_OE_HC = 2;
    localparam int unsigned IX_WE_LO = 3;

    logic [NRUN-1:0] run_act;
    logic [CW-1:0]   run_val [NRUN];
    acc_flags_t      flags;

    // Select the condition that each run counter measures.
    always_comb begin
        run_act[IX_OE_HI] = oe_n;
        run_act[IX_OE_LO] = !oe_n;
        run_act[IX_OE_HC] = oe_n && cas_n;
        run_act[IX_WE_LO] = !we_n;
    end

    for (genvar g = 0; g < NRUN; g++) begin : g_run
        edo_run_counter #(.CW(CW)) u_run (
            .clk    (clk),
            .rst_n  (rst_n),
            .active (run_act[g]),
            .run_q  (run_val[g])
        );
    end

    edo_access_track #(
        .CW(CW), .T_OEHC(T_OEHC), .T_OEP(T_OEP), .T_WPZ(T_WPZ)
    ) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .oe_n      (oe_n),
        .we_n      (we_n),
        .oe_hi_run (run_val[IX_OE_HI]),
        .oe_hc_run (run_val[IX_OE_HC]),
        .we_lo_run (run_val[IX_WE_LO]),
        .flags     (flags)
    );

    edo_drive_gate #(
        .CW(CW), .T_OD(T_OD), .T_OES(T_OES)
    ) u_gate (
        .flags     (flags),
        .oe_hi_run (run_val[IX_OE_HI]),
        .oe_lo_run (run_val[IX_OE_LO]),
        .we_lo_run (run_val[IX_WE_LO]),
        .dq_drive  (dq_drive)
    );

    // Bring the latched-data flag out to the port.
    always_comb data_valid = flags.valid;

endmodule

// File: rtl/edo_dq_ctrl_chk.sv
// Port-level checker for edo_dq_ctrl, attached with bind.
// Keeps its own count of consecutive high output-enable samples.
module edo_dq_ctrl_chk #(
    parameter int unsigned T_OD = 2
) (
    input logic clk,
    input logic rst_n,
    input logic ras_n,
    input logic cas_n,
    input logic oe_n,
    input logic we_n,
    input logic dq_drive,
    input logic data_valid
);

    logic [7:0] oe_run_q;

    // Independent run count of output enable held high.
    always_ff @(posedge clk) begin
        if (!rst_n || !oe_n)      oe_run_q <= '0;
        else if (oe_run_q != '1)  oe_run_q <= oe_run_q + 1'b1;
    end

    p_read_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n && $fell(cas_n) && we_n) |=> data_valid);

    p_disable_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_n && (oe_run_q >= 8'(T_OD))) |=> !dq_drive);

    p_we_low_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |=> !dq_drive);

    p_standby_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_n && cas_n) |=> (!dq_drive && !data_valid));

endmodule

bind edo_dq_ctrl edo_dq_ctrl_chk #(.T_OD(T_OD)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ras_n      (ras_n),
    .cas_n      (cas_n),
    .oe_n       (oe_n),
    .we_n       (we_n),
    .dq_drive   (dq_drive),
    .data_valid (data_valid)
);

// File: tb/sim_edo_dq_ctrl.sv
// Directed bench for edo_dq_ctrl: one task per scenario, inputs on negedge.
module sim_edo_dq_ctrl;

    logic clk = 1'b0;
    logic rst_n, ras_n, cas_n, oe_n, we_n;
    logic dq_drive, data_valid;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    always #10 clk = ~clk;

    edo_dq_ctrl #(.T_OD(2), .T_OES(2), .T_OEHC(3), .T_OEP(4), .T_WPZ(3)) u0 (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n),
        .oe_n(oe_n), .we_n(we_n), .dq_drive(dq_drive), .data_valid(data_valid)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic exp_drv, input logic exp_dv);
        n_chk++;
        if (dq_drive !== exp_drv || data_valid !== exp_dv) begin
            n_bad++;
            $display("FAIL %s: drive/valid actual %b/%b expected %b/%b",
                     req, dq_drive, data_valid, exp_drv, exp_dv);
        end
    endtask

    // Standby, then a read column fall with output enable low.
    task automatic start_read();
        ras_n = 1; cas_n = 1; oe_n = 0; we_n = 1;
        step(3);
        ras_n = 0; step(1);
        cas_n = 0; step(1);
    endtask

    task automatic t_reset();
        check("R11 reset", 0, 0);
    endtask

    task automatic t_read();
        start_read();
        check("R1 read drive", 1, 1);
    endtask

    task automatic t_oe_short();
        start_read();
        oe_n = 1; step(1); check("R2 od edge1", 1, 1);
        step(1);           check("R2 od edge2", 1, 1);
        step(1);           check("R2 od off", 0, 1);
        oe_n = 0; step(1); check("R3 oes pending", 0, 1);
        step(1);           check("R3 oes back", 1, 1);
    endtask

    task automatic t_oep_lock();
        start_read();
        oe_n = 1; step(4);
        oe_n = 0; step(4); check("R4 oep locked", 0, 1);
        cas_n = 1; step(1); check("R5 lock holds", 0, 1);
        cas_n = 0; step(1); check("R5 read clears", 1, 1);
    endtask

    task automatic t_oehc_lock();
        start_read();
        cas_n = 1; step(1); check("R6 cas high ras low", 1, 1);
        oe_n = 1; step(3);
        oe_n = 0; step(3); check("R6 oehc locked", 0, 1);
        cas_n = 0; step(1); check("R5 oehc cleared", 1, 1);
    endtask

    task automatic t_we_short();
        start_read();
        we_n = 0; step(1); check("R7 we low off", 0, 1);
        step(1);           check("R7 we low hold", 0, 1);
        we_n = 1; step(1); check("R8 short we back", 1, 1);
    endtask

    task automatic t_we_long();
        start_read();
        we_n = 0; step(3);
        we_n = 1; step(2); check("R9 wpz locked", 0, 1);
        cas_n = 1; step(1);
        cas_n = 0; step(1); check("R9 read unlocks", 1, 1);
    endtask

    task automatic t_early_write();
        start_read();
        cas_n = 1; step(1);
        we_n = 0; step(1);
        cas_n = 0; step(1); check("R10 write clears valid", 0, 0);
        we_n = 1; step(1);  check("R10 stays off", 0, 0);
    endtask

    task automatic t_standby();
        start_read();
        ras_n = 1; cas_n = 1; step(1); check("R11 standby", 0, 0);
    endtask

    task automatic t_cas_ras_high();
        ras_n = 1; cas_n = 1; oe_n = 0; we_n = 1; step(2);
        cas_n = 0; step(1); check("R12 no ras no valid", 0, 0);
        cas_n = 1; step(1);
    endtask

    initial begin
        rst_n = 0; ras_n = 1; cas_n = 1; oe_n = 1; we_n = 1;
        step(3);
        rst_n = 1; step(1);
        t_reset();
        t_read();
        t_oe_short();
        t_oep_lock();
        t_oehc_lock();
        t_we_short();
        t_we_long();
        t_early_write();
        t_standby();
        t_cas_ras_high();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule